// File: doc/BRIEF.md
# Request Aging Priority Promoter

This block keeps a small table of memory requests that are waiting for service. Each request arrives with a payload and a one-bit priority. A request that arrives at priority 1 is reported as urgent at once. A request that arrives at priority 0 starts a private wait counter. Once that counter reaches a programmable limit, the request is promoted to urgent. This stops low-priority traffic from starving behind a steady stream of urgent requests.

A downstream arbiter sees, for every table slot, a valid flag, the current urgency and the stored payload. When it grants a slot, it returns the slot index on an accept strobe, and the slot is freed at that clock edge. The wait limit sits in an 8-bit register that resets to 0x18. A one-cycle load strobe rewrites it, and every slot compares against the live value.

Top module: `req_aging_promoter`

## Requirements
- R1: After reset, no slot is valid, `in_ready_o` is 1 and the wait limit is 0x18. With that limit, a priority-0 entry written at edge E first reads urgent after edge E+25.
- R2: A request is written when `in_valid_i` and `in_ready_o` are both 1. It goes into the lowest-numbered free slot, and the slot's payload field (bits [16*i+15:16*i] of `ent_data_o` for slot i) holds the request data. `in_ready_o` is 0 exactly when all slots are valid. A request offered while `in_ready_o` is 0 changes no slot.
- R3: An entry written with priority 1 reads urgent (`ent_hi_o[i]`=1) from the edge that writes it.
- R4: An entry written with priority 0 at edge E, whose limit is T, reads not urgent through edge E+T and reads urgent from edge E+T+1. Its wait count is 0 after E and rises by one per edge, and the compare uses the count held before the edge.
- R5: With a limit of 0, a priority-0 entry reads not urgent right after it is written and reads urgent after the next edge.
- R6: Promotion is sticky. Raising the limit after an entry has become urgent leaves it urgent until it is accepted.
- R7: A load strobe on `cfg_we_i` stores `cfg_wait_i` at that edge, and all slots compare against the new limit from the following edge.
- R8: An accept strobe naming a valid slot clears that slot's valid and urgent flags at that edge. An accept strobe naming an empty slot changes no slot.
- R9: The wait count saturates at 255 instead of wrapping. With the limit at 255, a priority-0 entry written at edge E still becomes urgent after edge E+256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Load strobe for the wait limit |
| cfg_wait_i | input | 8 | New wait limit in clocks |
| in_valid_i | input | 1 | Incoming request present |
| in_ready_o | output | 1 | Table has a free slot |
| in_prio_i | input | 1 | Incoming request priority (1 = urgent) |
| in_data_i | input | 16 | Incoming request payload |
| ent_valid_o | output | 4 | Per-slot occupied flag |
| ent_hi_o | output | 4 | Per-slot effective urgency |
| ent_data_o | output | 64 | Per-slot payload, slot i at bits [16*i+15:16*i] |
| acc_valid_i | input | 1 | Arbiter accept strobe |
| acc_idx_i | input | 2 | Slot index being accepted |

## Verification
The bench probes the promotion edge on both sides: one clock before it, where the slot must still read low, and the clock itself, where it must read high. It does this at the reset limit, at limit 0 and at limit 255. An off-by-one compare, or a count that wraps and never reaches 255, shows up as a slot that turns urgent one edge early or late. The bench also offers a request to a full table and checks that no payload is overwritten. It re-accepts a slot that is already empty to catch a decoder that disturbs other slots. It raises the limit after promotion to catch an urgency flag that is recomputed instead of held.

// File: rtl/rap_pkg.sv
package rap_pkg;
   localparam int unsigned RAP_DEFAULT_WAIT = 32'h18;

   function automatic int unsigned rap_idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/rap_limit_reg.sv
module rap_limit_reg #(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned RESET_VAL = 8'h18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] value_i,
   output logic [CNT_W-1:0] limit_o
);
   localparam logic [CNT_W-1:0] RST = CNT_W'(RESET_VAL);

   always_ff @(posedge clk) begin
      if (!rst_n)      limit_o <= RST;
      else if (load_i) limit_o <= value_i;
   end
endmodule

// File: rtl/rap_slot_pick.sv
module rap_slot_pick #(
   parameter int unsigned ENTRIES = 4
) (
   input  logic [ENTRIES-1:0] busy_i,
   output logic [ENTRIES-1:0] pick_o,
   output logic               any_free_o
);
   assign any_free_o = ~&busy_i;

   generate
      if (ENTRIES == 1) begin : g_single
         assign pick_o = ~busy_i;
      end else begin : g_multi
         always_comb begin
            logic found;
            found  = 1'b0;
            pick_o = '0;
            for (int i = 0; i < ENTRIES; i++) begin
               if (!busy_i[i] && !found) begin
                  pick_o[i] = 1'b1;
                  found     = 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rap_slot.sv
module rap_slot #(
   parameter int unsigned DATA_W          = 16,
   parameter int unsigned CNT_W           = 8,
   parameter bit          FREEZE_ON_RAISE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              write_i,
   input  logic              prio_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              clear_i,
   input  logic [CNT_W-1:0]  limit_i,
   output logic              valid_o,
   output logic              hi_o,
   output logic [DATA_W-1:0] data_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic             born_hi;
   logic [CNT_W-1:0] age;
   logic             age_en;
   logic             due;

   generate
      if (FREEZE_ON_RAISE) begin : g_freeze
         assign age_en = valid_o && !hi_o && (age != CNT_MAX);
      end else begin : g_run
         assign age_en = valid_o && (age != CNT_MAX);
      end
   endgenerate

   assign due = valid_o && !born_hi && (age >= limit_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         hi_o    <= 1'b0;
         born_hi <= 1'b0;
         age     <= '0;
         data_o  <= '0;
      end else if (clear_i && valid_o) begin
         valid_o <= 1'b0;
         hi_o    <= 1'b0;
         born_hi <= 1'b0;
         age     <= '0;
      end else if (write_i) begin
         valid_o <= 1'b1;
         hi_o    <= prio_i;
         born_hi <= prio_i;
         age     <= '0;
         data_o  <= data_i;
      end else begin
         if (age_en) age  <= age + 1'b1;
         if (due)    hi_o <= 1'b1;
      end
   end
endmodule

// File: rtl/req_aging_promoter.sv
module req_aging_promoter #(
   parameter int unsigned ENTRIES    = 4,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned WAIT_RESET = rap_pkg::RAP_DEFAULT_WAIT,
   parameter bit          FREEZE_AGE = 1'b0,
   parameter int unsigned IDX_W      = rap_pkg::rap_idx_width(ENTRIES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we_i,
   input  logic [CNT_W-1:0]          cfg_wait_i,
   input  logic                      in_valid_i,
   output logic                      in_ready_o,
   input  logic                      in_prio_i,
   input  logic [DATA_W-1:0]         in_data_i,
   output logic [ENTRIES-1:0]        ent_valid_o,
   output logic [ENTRIES-1:0]        ent_hi_o,
   output logic [ENTRIES*DATA_W-1:0] ent_data_o,
   input  logic                      acc_valid_i,
   input  logic [IDX_W-1:0]          acc_idx_i
);
   initial begin
      if (ENTRIES < 1)   $error("ENTRIES must be at least 1");
      if (DATA_W < 1)    $error("DATA_W must be at least 1");
      if (CNT_W < 2)     $error("CNT_W must be at least 2");
      if (WAIT_RESET >= (1 << CNT_W)) $error("WAIT_RESET does not fit CNT_W");
   end

   logic [CNT_W-1:0]   limit;
   logic [ENTRIES-1:0] pick;
   logic               any_free;
   logic               take;

   rap_limit_reg #(.CNT_W(CNT_W), .RESET_VAL(WAIT_RESET)) u_limit (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (cfg_we_i),
      .value_i (cfg_wait_i),
      .limit_o (limit)
   );

   rap_slot_pick #(.ENTRIES(ENTRIES)) u_pick (
      .busy_i     (ent_valid_o),
      .pick_o     (pick),
      .any_free_o (any_free)
   );

   assign in_ready_o = any_free;
   assign take       = in_valid_i && any_free;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      logic hit;
      assign hit = acc_valid_i && (acc_idx_i == IDX_W'(g));

      rap_slot #(
         .DATA_W          (DATA_W),
         .CNT_W           (CNT_W),
         .FREEZE_ON_RAISE (FREEZE_AGE)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .write_i (take && pick[g]),
         .prio_i  (in_prio_i),
         .data_i  (in_data_i),
         .clear_i (hit),
         .limit_i (limit),
         .valid_o (ent_valid_o[g]),
         .hi_o    (ent_hi_o[g]),
         .data_o  (ent_data_o[g*DATA_W +: DATA_W])
      );
   end
endmodule

// File: rtl/rap_checker.sv
module rap_checker #(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned IDX_W   = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid_i,
   input logic               in_ready_o,
   input logic [ENTRIES-1:0] ent_valid_o,
   input logic [ENTRIES-1:0] ent_hi_o,
   input logic               acc_valid_i,
   input logic [IDX_W-1:0]   acc_idx_i
);
   AST_READY_TRACKS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready_o == !(&ent_valid_o)); // R2

   AST_BLOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && !in_ready_o && !acc_valid_i) |=> (ent_valid_o == $past(ent_valid_o))); // R2

   AST_ONE_WRITE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ent_valid_o & ~$past(ent_valid_o)) <= 1); // R2

   AST_ACCEPT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid_i && (int'(acc_idx_i) < ENTRIES)) |=> !ent_valid_o[$past(acc_idx_i)]); // R8

   for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
      AST_URGENT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
         ent_hi_o[g] |-> ent_valid_o[g]); // R8

      AST_URGENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (ent_hi_o[g] && !(acc_valid_i && acc_idx_i == IDX_W'(g))) |=> ent_hi_o[g]); // R6
   end
endmodule

bind req_aging_promoter rap_checker #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid_i  (in_valid_i),
   .in_ready_o  (in_ready_o),
   .ent_valid_o (ent_valid_o),
   .ent_hi_o    (ent_hi_o),
   .acc_valid_i (acc_valid_i),
   .acc_idx_i   (acc_idx_i)
);

// File: tb/req_aging_promoter_test.sv
`timescale 1ns/1ps
module req_aging_promoter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_wait = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic        in_prio = 1'b0;
   logic [15:0] in_data = '0;
   logic [3:0]  ent_valid;
   logic [3:0]  ent_hi;
   logic [63:0] ent_data;
   logic        acc_valid = 1'b0;
   logic [1:0]  acc_idx = '0;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;
   logic [3:0] mdl = '0;
   logic [17:0] exp_q[$];
   logic [3:0] prev_valid = '0;

   always #2.5 clk = ~clk;

   req_aging_promoter uut (
      .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_wait_i(cfg_wait),
      .in_valid_i(in_valid), .in_ready_o(in_ready), .in_prio_i(in_prio),
      .in_data_i(in_data), .ent_valid_o(ent_valid), .ent_hi_o(ent_hi),
      .ent_data_o(ent_data), .acc_valid_i(acc_valid), .acc_idx_i(acc_idx)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic submit(input logic p, input logic [15:0] d);
      int slot = -1;
      for (int i = 0; i < 4; i++) if (!mdl[i] && slot < 0) slot = i;
      if (slot >= 0) begin
         exp_q.push_back({slot[1:0], d});
         mdl[slot] = 1'b1;
      end
      in_valid = 1'b1; in_prio = p; in_data = d;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic accept(input logic [1:0] idx);
      acc_valid = 1'b1; acc_idx = idx;
      @(negedge clk);
      acc_valid = 1'b0;
      mdl[idx] = 1'b0;
   endtask

   task automatic set_limit(input logic [7:0] v);
      cfg_we = 1'b1; cfg_wait = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // monitor: scoreboard of slot writes (R2)
   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < 4; i++) begin
            if (ent_valid[i] && !prev_valid[i]) begin
               if (exp_q.size() == 0) begin
                  check(1'b0, "R2 unexpected write", 32'(i), 32'hFFFF);
               end else begin
                  logic [17:0] e;
                  e = exp_q.pop_front();
                  check(e[17:16] == 2'(i), "R2 slot order", 32'(i), 32'(e[17:16]));
                  check(ent_data[i*16 +: 16] == e[15:0], "R2 payload",
                        32'(ent_data[i*16 +: 16]), 32'(e[15:0]));
               end
            end
         end
      end
      prev_valid = ent_valid;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      check(ent_valid == 4'b0, "R1 reset valid", 32'(ent_valid), 0);
      check(in_ready == 1'b1, "R1 reset ready", 32'(in_ready), 1);

      // R1/R4: default limit 0x18
      submit(1'b0, 16'hA001);
      tick(24);
      check(ent_hi[0] == 1'b0, "R4 before limit", 32'(ent_hi[0]), 0);
      tick(1);
      check(ent_hi[0] == 1'b1, "R1 default limit promote", 32'(ent_hi[0]), 1);

      // R3: urgent on entry
      submit(1'b1, 16'hB002);
      check(ent_hi[1] == 1'b1, "R3 prio1 urgent", 32'(ent_hi[1]), 1);

      // R5/R7: limit 0
      set_limit(8'd0);
      submit(1'b0, 16'hC003);
      check(ent_hi[2] == 1'b0, "R5 not yet", 32'(ent_hi[2]), 0);
      tick(1);
      check(ent_hi[2] == 1'b1, "R5 limit zero", 32'(ent_hi[2]), 1);

      // R2: full table
      submit(1'b0, 16'hD004);
      check(in_ready == 1'b0, "R2 full not ready", 32'(in_ready), 0);
      submit(1'b1, 16'hFFFF);
      check(ent_valid == 4'b1111, "R2 full ignored valid", 32'(ent_valid), 32'hF);
      check(ent_data[63:48] == 16'hD004, "R2 full ignored data", 32'(ent_data[63:48]), 32'hD004);

      // R6: sticky after limit raise
      set_limit(8'd255);
      tick(3);
      check(ent_hi == 4'b1111, "R6 sticky", 32'(ent_hi), 32'hF);

      // R8: accept and empty accept
      accept(2'd1);
      check(ent_valid == 4'b1101, "R8 accept clears", 32'(ent_valid), 32'hD);
      check(ent_hi == 4'b1101, "R8 accept hi", 32'(ent_hi), 32'hD);
      accept(2'd1);
      check(ent_valid == 4'b1101, "R8 empty accept valid", 32'(ent_valid), 32'hD);
      check(ent_hi == 4'b1101, "R8 empty accept hi", 32'(ent_hi), 32'hD);

      // R9: limit 255, saturating count
      submit(1'b0, 16'hE005);
      tick(255);
      check(ent_hi[1] == 1'b0, "R9 before 256", 32'(ent_hi[1]), 0);
      tick(1);
      check(ent_hi[1] == 1'b1, "R9 promote at 256", 32'(ent_hi[1]), 1);

      for (int i = 0; i < 4; i++) accept(2'(i));
      check(ent_valid == 4'b0, "R8 all cleared", 32'(ent_valid), 0);
      check(in_ready == 1'b1, "R2 ready again", 32'(in_ready), 1);
      check(exp_q.size() == 0, "R2 all writes seen", 32'(exp_q.size()), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule